// File: doc/BRIEF.md
# Parallel EEPROM Page-Load Controller

This block models, in the clock domain, the control logic of a byte-alterable parallel EEPROM. A host drives three active-low strobes (chip enable, output enable, write enable), a 16-bit address and an 8-bit data bus. Every input is sampled on the system clock. A write strobe that stays low long enough counts as a byte load. Byte loads collect in a page buffer that holds one page of 128 bytes.

The first accepted load locks the page address. After that, each new load must arrive before a load window, counted in clocks, runs out. When the window expires with no new load, the block starts an internal programming cycle. The busy output is high for a fixed number of clocks. At the end of that cycle, the loaded bytes are written into a storage array that holds a parameterised number of pages. Reads drive the stored byte through a separate output. The bus enable goes low whenever a read is not selected, which releases the bus. A supply-low input blocks all writes.

Top module: `eeprom_page_loader`

## Requirements
- R1: `dataOe` is 1 exactly when `ceN` and `oeN` are both 0. Otherwise the data bus is released and `dataOe` is 0.
- R2: A read returns the stored byte at storage index {addr[8:7], addr[6:0]}. After reset every byte reads 8'hFF. A read during programming returns the contents held before that programming cycle.
- R3: A write strobe is recognised only while `ceN`=0, `weN`=0 and `oeN`=1. The address is taken in the first cycle both enables are low. The data is the value present in the last cycle the strobe is held.
- R4: A write strobe held for fewer than GLITCH_CYC consecutive cycles has no effect.
- R5: The page buffer keeps one byte per offset addr[6:0], for up to 128 bytes. A later load to the same offset replaces the earlier one. Offsets that are not loaded keep their previous stored contents.
- R6: Programming starts once LOAD_WINDOW cycles pass after the last accepted load with no new accepted load. `busy` is then high for exactly PROG_CYC cycles, and the page contents are readable when it falls.
- R7: A load whose page bits addr[15:7] differ from the locked page is discarded. It sets the sticky `pageErr` flag and does not restart the load window.
- R8: While `busy` is high, write strobes are ignored.
- R9: No write is accepted while `supplyLow` is 1 or `oeN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | 16 | Byte address; bits 15:7 select the page |
| dataIn | input | 8 | Write data from the host |
| supplyLow | input | 1 | Supply-low sense; 1 blocks all writes |
| dataOut | output | 8 | Read data, valid while dataOe is 1 |
| dataOe | output | 1 | Bus drive enable for dataOut |
| busy | output | 1 | High while the programming cycle runs |
| pageErr | output | 1 | Sticky flag for a discarded wrong-page load |

## Verification
Most faults in the internal state show up only after the next programming cycle ends. A wrong offset capture, a missed overwrite or a load mask that was not cleared gives wrong read data once `busy` falls. That is at most LOAD_WINDOW plus PROG_CYC cycles after the faulty load. A fault in the window or glitch counters shows up sooner, as `busy` rising too early, too late or not at all. A bad page lock shows at once as a wrong `pageErr` value. Reads are therefore checked right after each busy period, and also during one busy period, to catch an early commit.

// File: rtl/epl_pkg.sv
package epl_pkg;

  // Strobes passed from the control FSM to the datapath
  typedef struct packed {
    logic addrCapture;  // first cycle of a write strobe
    logic lockPage;     // first accepted load of a sequence
    logic holdData;     // strobe still held: track data bus
    logic commitByte;   // accepted strobe just ended
    logic programDone;  // final cycle of programming
  } eplStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } eplState_t;

endpackage

// File: rtl/epl_ctrl.sv
module epl_ctrl
  import epl_pkg::*;
#(
  parameter int GLITCH_CYC  = 3,
  parameter int LOAD_WINDOW = 64,
  parameter int PROG_CYC    = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        weN,
  input  logic        supplyLow,
  input  logic        pageMatch,
  output eplStrobes_t strobes,
  output logic        busy,
  output logic        pageErr
);

  localparam int GL_W  = $clog2(GLITCH_CYC + 1);
  localparam int WIN_W = $clog2(LOAD_WINDOW);
  localparam int PRG_W = $clog2(PROG_CYC);

  eplState_t  state;
  logic [GL_W-1:0]  glitchCnt;
  logic [WIN_W-1:0] winCnt;
  logic [PRG_W-1:0] progCnt;
  logic prevActive, accepted;
  logic writeActive, qualifyNow, loadOk, expire, progEnd;

  assign writeActive = !ceN && !weN && oeN && !supplyLow && (state != ST_PROG);
  assign qualifyNow  = writeActive && (glitchCnt == GL_W'(GLITCH_CYC - 1));
  assign loadOk      = (state == ST_IDLE) || pageMatch;
  assign expire      = (state == ST_LOAD) && (winCnt == WIN_W'(LOAD_WINDOW - 1))
                       && !accepted && !(qualifyNow && loadOk);
  assign progEnd     = (state == ST_PROG) && (progCnt == PRG_W'(PROG_CYC - 1));

  // Strobe qualification: count consecutive active cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glitchCnt  <= '0;
      prevActive <= 1'b0;
      accepted   <= 1'b0;
      pageErr    <= 1'b0;
    end else begin
      prevActive <= writeActive;
      if (!writeActive) glitchCnt <= '0;
      else if (glitchCnt != GL_W'(GLITCH_CYC)) glitchCnt <= glitchCnt + 1'b1;
      if (!writeActive) accepted <= 1'b0;
      else if (qualifyNow) accepted <= loadOk;
      if (qualifyNow && !loadOk) pageErr <= 1'b1;
    end
  end

  // Sequence FSM with load window and programming timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      progCnt <= '0;
    end else begin
      if (qualifyNow && loadOk) winCnt <= '0;
      else if (state == ST_LOAD && winCnt != WIN_W'(LOAD_WINDOW - 1))
        winCnt <= winCnt + 1'b1;
      unique case (state)
        ST_IDLE: if (qualifyNow) state <= ST_LOAD;
        ST_LOAD: if (expire) begin
          state   <= ST_PROG;
          progCnt <= '0;
        end
        ST_PROG: begin
          if (progEnd) state <= ST_IDLE;
          else progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.addrCapture = writeActive && !prevActive;
    strobes.lockPage    = qualifyNow && (state == ST_IDLE);
    strobes.holdData    = writeActive;
    strobes.commitByte  = prevActive && !writeActive && accepted;
    strobes.programDone = progEnd;
  end

  assign busy = (state == ST_PROG);

endmodule

// File: rtl/epl_datapath.sv
module epl_datapath
  import epl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  parameter int MEM_PAGES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  eplStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ceN,
  input  logic              oeN,
  output logic              pageMatch,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int OFF_BITS  = $clog2(PAGE_BYTES);
  localparam int PG_SEL    = $clog2(MEM_PAGES);
  localparam int PAGE_W    = ADDR_W - OFF_BITS;
  localparam int MEM_BYTES = PAGE_BYTES * MEM_PAGES;
  localparam int IDX_W     = OFF_BITS + PG_SEL;

  logic [ADDR_W-1:0]   pendAddr;
  logic [PAGE_W-1:0]   lockedPage;
  logic [DATA_W-1:0]   dataHold;
  logic [DATA_W-1:0]   pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loadMask;
  logic [DATA_W-1:0]   mem [MEM_BYTES];
  logic [OFF_BITS-1:0] pendOff;
  logic [PG_SEL-1:0]   lockedSel;
  logic [IDX_W-1:0]    rdIdx;

  assign pendOff   = pendAddr[OFF_BITS-1:0];
  assign lockedSel = lockedPage[PG_SEL-1:0];
  assign pageMatch = (pendAddr[ADDR_W-1:OFF_BITS] == lockedPage);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr   <= '0;
      lockedPage <= '0;
      dataHold   <= '0;
    end else begin
      if (strobes.addrCapture) pendAddr <= addr;
      if (strobes.lockPage) lockedPage <= pendAddr[ADDR_W-1:OFF_BITS];
      if (strobes.holdData) dataHold <= dataIn;
    end
  end

  // One buffer slot and load flag per page offset
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[g]  <= '0;
        loadMask[g] <= 1'b0;
      end else if (strobes.commitByte && pendOff == OFF_BITS'(g)) begin
        pageBuf[g]  <= dataHold;
        loadMask[g] <= 1'b1;
      end else if (strobes.programDone) begin
        loadMask[g] <= 1'b0;
      end
    end
  end

  // Storage array: loaded bytes land on the last programming cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '1;
    end else if (strobes.programDone) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (loadMask[i]) mem[{lockedSel, OFF_BITS'(i)}] <= pageBuf[i];
    end
  end

  assign rdIdx   = addr[IDX_W-1:0];
  assign dataOe  = !ceN && !oeN;
  assign dataOut = dataOe ? mem[rdIdx] : '0;

endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader
  import epl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int MEM_PAGES   = 4,
  parameter int GLITCH_CYC  = 3,
  parameter int LOAD_WINDOW = 64,
  parameter int PROG_CYC    = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              supplyLow,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy,
  output logic              pageErr
);

  eplStrobes_t strobes;
  logic pageMatch;

  epl_ctrl #(
    .GLITCH_CYC (GLITCH_CYC),
    .LOAD_WINDOW(LOAD_WINDOW),
    .PROG_CYC   (PROG_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceN      (ceN),
    .oeN      (oeN),
    .weN      (weN),
    .supplyLow(supplyLow),
    .pageMatch(pageMatch),
    .strobes  (strobes),
    .busy     (busy),
    .pageErr  (pageErr)
  );

  epl_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES),
    .MEM_PAGES (MEM_PAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addr     (addr),
    .dataIn   (dataIn),
    .ceN      (ceN),
    .oeN      (oeN),
    .pageMatch(pageMatch),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );

endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 200
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              supplyLow,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              busy,
  input logic              pageErr
);

  int busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= 0;
    else if (!busy) busyCnt <= 0;
    else busyCnt <= busyCnt + 1;
  end

  // R6: programming lasts exactly PROG_CYC cycles
  assert_prog_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == PROG_CYC);

  // R7: wrong-page flag never clears
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |=> pageErr);

  // R8: no load is evaluated while programming
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pageErr) |-> !$past(busy));

  // R9: a load is only evaluated under valid write conditions
  assert_inhibit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pageErr) |-> $past(!supplyLow && oeN && !ceN && !weN));

  // R2: stored contents change only when programming ends
  assert_read_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dataOe) && dataOe && $stable(addr) && !$fell(busy)) |-> $stable(dataOut));

endmodule

bind eeprom_page_loader epl_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .PROG_CYC(PROG_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .oeN      (oeN),
  .weN      (weN),
  .supplyLow(supplyLow),
  .addr     (addr),
  .dataOut  (dataOut),
  .dataOe   (dataOe),
  .busy     (busy),
  .pageErr  (pageErr)
);

// File: tb/tb_eeprom_page_loader.sv
`timescale 1ns/1ps
module tb_eeprom_page_loader;

  localparam int GLITCH = 3;
  localparam int WIN    = 64;
  localparam int PROG   = 200;

  logic clk = 0, rstN = 0;
  logic ceN = 1, oeN = 1, weN = 1, supplyLow = 0;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic dataOe, busy, pageErr;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [7:0] refMem [512];
  logic [7:0] shData [128];
  bit         shMask [128];
  int         shPage;

  logic [15:0] qAddr[$];
  logic [7:0]  qData[$];
  string       qTag[$];
  bit          readReq = 0;

  always #2.5 clk = ~clk;

  eeprom_page_loader #(
    .GLITCH_CYC(GLITCH), .LOAD_WINDOW(WIN), .PROG_CYC(PROG)
  ) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .supplyLow(supplyLow),
    .dataOut(dataOut), .dataOe(dataOe), .busy(busy), .pageErr(pageErr)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read items and compares
  always @(negedge clk) begin
    if (readReq && qAddr.size() > 0) begin
      logic [7:0] e;
      string t;
      e = qData.pop_front();
      t = qTag.pop_front();
      void'(qAddr.pop_front());
      check(dataOe === 1'b1, {t, " R1 oe"}, int'(dataOe), 1);
      check(dataOut === e, t, int'(dataOut), int'(e));
    end
  end

  task automatic doRead(logic [15:0] a, string tag);
    @(negedge clk);
    addr = a; ceN = 0; oeN = 0;
    qAddr.push_back(a);
    qData.push_back(refMem[int'(a[8:0])]);
    qTag.push_back(tag);
    @(posedge clk); readReq = 1;
    @(posedge clk); readReq = 0;
    @(negedge clk); ceN = 1; oeN = 1;
  endtask

  task automatic doWrite(logic [15:0] a, logic [7:0] d, int lowCyc, bit expectTaken);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 0; weN = 0;
    repeat (lowCyc) @(negedge clk);
    weN = 1; ceN = 1;
    repeat (2) @(negedge clk);
    if (expectTaken) begin
      shPage = int'(a[8:7]);
      shData[a[6:0]] = d;
      shMask[a[6:0]] = 1;
    end
  endtask

  task automatic commitShadow();
    for (int i = 0; i < 128; i++)
      if (shMask[i]) begin
        refMem[shPage*128 + i] = shData[i];
        shMask[i] = 0;
      end
  endtask

  task automatic waitRise(string tag);
    int n = 0;
    while (!busy && n < WIN + 40) begin @(negedge clk); n++; end
    check(busy === 1'b1, {tag, " busy rises"}, int'(busy), 1);
  endtask

  task automatic waitFall();
    while (busy) @(negedge clk);
    commitShadow();
  endtask

  task automatic expectNoBusy(string tag);
    bit seen = 0;
    repeat (WIN + 30) begin @(negedge clk); if (busy) seen = 1; end
    check(!seen, tag, int'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) refMem[i] = 8'hFF;
    for (int i = 0; i < 128; i++) shMask[i] = 0;
    shPage = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // Reset state
    check(busy === 1'b0, "R6 reset busy", int'(busy), 0);
    check(pageErr === 1'b0, "R7 reset err", int'(pageErr), 0);
    check(dataOe === 1'b0, "R1 released", int'(dataOe), 0);
    doRead(16'h0005, "R2 erased");
    @(negedge clk); oeN = 0;
    @(negedge clk);
    check(dataOe === 1'b0, "R1 oe only", int'(dataOe), 0);
    oeN = 1;

    // R3 R5 R6: page load with overwrite, gap under window
    doWrite(16'h0080, 8'h11, 3, 1);
    doWrite(16'h0081, 8'h22, 4, 1);
    doWrite(16'h0082, 8'h33, 3, 1);
    doWrite(16'h0082, 8'h3C, 5, 1);
    repeat (WIN / 2) @(negedge clk);
    check(busy === 1'b0, "R6 window open", int'(busy), 0);
    doWrite(16'h0083, 8'h44, 3, 1);
    waitRise("R6");
    begin
      int n = 1;
      @(negedge clk);
      while (busy) begin n++; @(negedge clk); end
      check(n == PROG, "R6 busy length", n, PROG);
      commitShadow();
    end
    doRead(16'h0080, "R3 byte0");
    doRead(16'h0082, "R5 overwrite");
    doRead(16'h0083, "R6 last");
    doRead(16'h0085, "R5 untouched");

    // R4: short strobe ignored
    doWrite(16'h0100, 8'hAB, 2, 0);
    expectNoBusy("R4 no program");
    doRead(16'h0100, "R4 unchanged");

    // R9: oe low or supply low blocks writes
    @(negedge clk);
    addr = 16'h0101; dataIn = 8'hCD; ceN = 0; weN = 0; oeN = 0;
    repeat (5) @(negedge clk);
    ceN = 1; weN = 1; oeN = 1;
    supplyLow = 1;
    doWrite(16'h0102, 8'hEF, 5, 0);
    supplyLow = 0;
    expectNoBusy("R9 inhibit");
    doRead(16'h0101, "R9 oe blocked");
    doRead(16'h0102, "R9 supply blocked");

    // R7: wrong-page load discarded
    doWrite(16'h0001, 8'h5A, 3, 1);
    doWrite(16'h0181, 8'hA5, 3, 0);
    check(pageErr === 1'b1, "R7 err set", int'(pageErr), 1);
    waitRise("R7");
    waitFall();
    doRead(16'h0001, "R7 locked page");
    doRead(16'h0181, "R7 discarded");
    check(pageErr === 1'b1, "R7 sticky", int'(pageErr), 1);

    // R8 and R2: writes ignored and old data read during busy
    doWrite(16'h0100, 8'h20, 3, 1);
    waitRise("R8");
    doRead(16'h0100, "R2 old during busy");
    doWrite(16'h0109, 8'h99, 4, 0);
    waitFall();
    doRead(16'h0100, "R2 new after busy");
    doRead(16'h0109, "R8 ignored");
    expectNoBusy("R8 no late program");

    // R5: full 128-byte page
    for (int i = 0; i < 128; i++)
      doWrite(16'h0180 + 16'(i), 8'(i) ^ 8'h5A, 3, 1);
    waitRise("R5 full");
    waitFall();
    doRead(16'h0180, "R5 full first");
    doRead(16'h01C0, "R5 full mid");
    doRead(16'h01FF, "R5 full last");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule